// File: doc/BRIEF.md
# Tamper Input Debouncer

This block cleans up a set of tamper-detection input pins before any event logic looks at them. Every pin is first brought into the clock domain through two flip-flops and is then sampled on a strobe. The strobe comes from a free-running counter that divides the base clock by a power of two, selected by a 3-bit rate code. The last three samples of each pin are kept. A per-block rule decides when the filtered level moves. Under the strict rule, all three samples must agree. Under the majority rule, the level follows whatever value at least two of the three samples hold.

A mode input picks one of two behaviours. In synchronous mode the filtered level is decided only from the sample history. In asynchronous mode the first edge seen on a synchronized pin is passed to the output straight away, without waiting for a strobe. The pin is then locked until three fresh samples have been taken and they agree. The agreed value becomes the output, and the pin is re-armed.

Any change of a filtered level raises a sticky tamper flag. When request mode is on, the flag is presented as a request, and a timestamp-read strobe clears the flag. When request mode is off, the request stays low and timestamp reads leave the flag as it is.

Top module: `tamper_debounce`

## Requirements
- R1: After a synchronous active-low reset, every filtered output, the tamper flag and the request output are 0, and the sample history of every pin is all zeros.
- R2: With rate code k (0 to 7), the sample strobe fires once every 2^(k+1) clocks, taken from a free-running 8-bit counter that starts at 0 after reset and fires when its low k+1 bits are all ones.
- R3: Synchronous mode (mode input 0) with the majority input 0: a filtered output takes value v on the clock after its three held samples all equal v, and otherwise holds. A pin change reaches the sampler after two synchronizer clocks.
- R4: Synchronous mode with the majority input 1: a filtered output equals the majority value of its three held samples, one clock after the history changes.
- R5: Asynchronous mode (mode input 1): when a pin is armed and its synchronized value differs from its output, the output takes that value on the next clock, without waiting for a strobe, and the pin becomes locked. While locked, pin changes do not move the output.
- R6: A locked pin is released on the first clock after at least three strobes have passed since it locked and its three held samples are equal. At release the output takes the held sample value.
- R7: Any change in any filtered output sets the tamper flag one clock later, and the flag stays set until it is cleared.
- R8: With request mode 1, a timestamp-read strobe clears the flag on the next clock, unless a filtered change sets it on that same clock, in which case setting wins.
- R9: With request mode 0, a timestamp-read strobe leaves the flag unchanged and the request output is 0.
- R10: With request mode 1, the request output equals the tamper flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_code | input | 3 | Sample rate code k, strobe period 2^(k+1) clocks |
| maj_en | input | 1 | 0: all three samples equal; 1: two-of-three majority |
| async_en | input | 1 | 0: synchronous mode; 1: asynchronous first-edge mode |
| req_en | input | 1 | Request mode: enables the request output and clear-on-read |
| ts_rd | input | 1 | Timestamp-read strobe, one clock per read |
| pins_raw | input | N_PINS | Raw tamper pins |
| filt_out | output | N_PINS | Filtered pin levels |
| tamper_flag | output | 1 | Sticky flag, set by any filtered change |
| dma_req | output | 1 | Request output, the flag gated by request mode |

## Verification
The bench aims short glitches of one and two samples at the strict filter. A design that acted on fewer than three agreeing samples would let those glitches through. The same glitches go to the majority filter, where a lone odd sample must be outvoted. In asynchronous mode it sends a pulse shorter than the lock window. A design that never released the lock would freeze the output at the glitch level, and one that released too early would follow the bounce. It also checks the slowest rate code for an off-by-one in the strobe period, and a timestamp read in the same clock as a filtered change, where a wrong priority would lose the event.

// File: rtl/tdb_pkg.sv
// Package: shared constants and helpers for the tamper debouncer.
// Assumes the rate code is 3 bits, so the divider counter is 2^3 = 8 bits.
package tdb_pkg;
    localparam int RATE_W = 3;
    localparam int CNT_W  = 1 << RATE_W;

    // Majority of three single-bit samples.
    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
    endfunction

    // True when all three samples hold the same value.
    function automatic logic same3(input logic [2:0] s);
        return (s == 3'b000) || (s == 3'b111);
    endfunction
endpackage

// File: rtl/tdb_prescale.sv
// Module: free-running divider that produces the sample strobe.
// The strobe fires once every 2^(code+1) clocks, when the low code+1 bits
// of the counter are all ones. Assumes the code may change at any time;
// the counter is never reloaded, so the phase stays continuous.
module tdb_prescale
    import tdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] code,
    output logic              strobe
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Mask of the counter bits that must all be one for a strobe.
    always_comb begin
        mask   = (CNT_W'(2) << code) - CNT_W'(1);
        strobe = ((cnt & mask) == mask);
    end

    // Free-running count, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/tdb_filter.sv
// Module: debounce filter for one tamper pin.
// Two-flop synchronizer, three-sample history shifted on the strobe, and
// strict or majority decision. In asynchronous mode the first edge passes
// at once and the pin is locked until three new agreeing samples exist.
// Assumes mode inputs are steady while in use.
module tdb_filter
    import tdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic maj_en,
    input  logic async_en,
    input  logic pin_raw,
    output logic filt
);
    logic       sync_a, sync_b;
    logic [2:0] hist;
    logic       locked, locked_nx;
    logic [1:0] lock_cnt, lock_cnt_nx;
    logic       filt_nx;

    // Two-stage synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= pin_raw;
            sync_b <= sync_a;
        end
    end

    // Sample history, newest in bit 0, shifted on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      hist <= 3'b000;
        else if (strobe) hist <= {hist[1:0], sync_b};
    end

    // Next output level and lock state from the mode and history.
    always_comb begin
        filt_nx     = filt;
        locked_nx   = locked;
        lock_cnt_nx = lock_cnt;
        if (!async_en) begin
            locked_nx   = 1'b0;
            lock_cnt_nx = 2'd0;
            if (maj_en)           filt_nx = maj3(hist);
            else if (same3(hist)) filt_nx = hist[0];
        end else if (!locked) begin
            if (sync_b != filt) begin
                filt_nx     = sync_b;
                locked_nx   = 1'b1;
                lock_cnt_nx = 2'd0;
            end
        end else if ((lock_cnt == 2'd3) && same3(hist)) begin
            filt_nx   = hist[0];
            locked_nx = 1'b0;
        end else if (strobe && (lock_cnt != 2'd3)) begin
            lock_cnt_nx = lock_cnt + 2'd1;
        end
    end

    // Output and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt     <= 1'b0;
            locked   <= 1'b0;
            lock_cnt <= 2'd0;
        end else begin
            filt     <= filt_nx;
            locked   <= locked_nx;
            lock_cnt <= lock_cnt_nx;
        end
    end
endmodule

// File: rtl/tdb_flag.sv
// Module: sticky tamper flag and request output.
// Sets one clock after any filtered level changes; a timestamp read clears
// it only in request mode, and a same-clock change takes priority.
module tdb_flag #(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] filt,
    input  logic              req_en,
    input  logic              ts_rd,
    output logic              flag,
    output logic              req
);
    logic [N_PINS-1:0] filt_d;
    logic              any_chg;

    // Detect a change of any filtered level against last clock.
    always_comb any_chg = |(filt ^ filt_d);

    // Delay copy and flag update with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_d <= '0;
            flag   <= 1'b0;
        end else begin
            filt_d <= filt;
            if (any_chg)              flag <= 1'b1;
            else if (ts_rd && req_en) flag <= 1'b0;
        end
    end

    // Request is the flag, gated by request mode.
    always_comb req = flag & req_en;
endmodule

// File: rtl/tamper_debounce.sv
// Module: top of the tamper input debouncer.
// One shared strobe generator, one filter per pin (generated), one flag.
// Assumes all inputs are synchronous to clk except pins_raw.
module tamper_debounce
    import tdb_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rate_code,
    input  logic              maj_en,
    input  logic              async_en,
    input  logic              req_en,
    input  logic              ts_rd,
    input  logic [N_PINS-1:0] pins_raw,
    output logic [N_PINS-1:0] filt_out,
    output logic              tamper_flag,
    output logic              dma_req
);
    logic strobe;

    tdb_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (rate_code),
        .strobe (strobe)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        tdb_filter u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe   (strobe),
            .maj_en   (maj_en),
            .async_en (async_en),
            .pin_raw  (pins_raw[g]),
            .filt     (filt_out[g])
        );
    end

    tdb_flag #(.N_PINS(N_PINS)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .filt   (filt_out),
        .req_en (req_en),
        .ts_rd  (ts_rd),
        .flag   (tamper_flag),
        .req    (dma_req)
    );
endmodule

// File: rtl/tamper_debounce_chk.sv
// Checker: port-level properties of the tamper debouncer, bound to the top.
module tamper_debounce_chk #(
    parameter int N_PINS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_en,
    input logic              ts_rd,
    input logic [N_PINS-1:0] filt_out,
    input logic              tamper_flag,
    input logic              dma_req
);
    // R7: a filtered change is followed by a set flag
    assert_flag_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_out != $past(filt_out)) |=> tamper_flag);

    // R9: no request while request mode is off
    assert_no_req_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |-> !dma_req);

    // R9: reads cannot clear the flag while request mode is off
    assert_flag_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_flag && !req_en) |=> tamper_flag);

    // R8: a read in request mode with no change clears the flag
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && ts_rd && (filt_out == $past(filt_out))) |=> !tamper_flag);
endmodule

bind tamper_debounce tamper_debounce_chk #(.N_PINS(N_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_en      (req_en),
    .ts_rd       (ts_rd),
    .filt_out    (filt_out),
    .tamper_flag (tamper_flag),
    .dma_req     (dma_req)
);

// File: tb/tamper_debounce_tb.sv
// Bench: behavioural per-clock model compared with the design every cycle.
module tamper_debounce_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   rate_code = 3'd0;
    logic         maj_en = 1'b0, async_en = 1'b0, req_en = 1'b0, ts_rd = 1'b0;
    logic [N-1:0] pins_raw = '0;
    logic [N-1:0] filt_out;
    logic         tamper_flag, dma_req;

    int tests = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    tamper_debounce #(.N_PINS(N)) u_dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    // Behavioural model state
    int m_cnt, m_flag, per;
    int m_s1[N], m_s2[N], m_out[N], m_prev[N], m_lk[N], m_lc[N];
    int m_hist[N][$];   // newest at index 0, three entries
    bit stb, chg;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0;
            for (int i = 0; i < N; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_out[i] = 0; m_prev[i] = 0;
                m_lk[i] = 0; m_lc[i] = 0; m_hist[i] = '{0, 0, 0};
            end
        end else begin
            per = 2 << rate_code;
            stb = ((m_cnt % per) == per - 1);
            chg = 0;
            for (int i = 0; i < N; i++) begin
                int a, b, c;
                bool_eq: begin end
                a = m_hist[i][0]; b = m_hist[i][1]; c = m_hist[i][2];
                if (m_out[i] != m_prev[i]) chg = 1;
                m_prev[i] = m_out[i];
                if (!async_en) begin
                    m_lk[i] = 0; m_lc[i] = 0;
                    if (maj_en) m_out[i] = (a + b + c >= 2) ? 1 : 0;
                    else if (a == b && b == c) m_out[i] = a;
                end else if (!m_lk[i]) begin
                    if (m_s2[i] != m_out[i]) begin
                        m_out[i] = m_s2[i]; m_lk[i] = 1; m_lc[i] = 0;
                    end
                end else if (m_lc[i] == 3 && a == b && b == c) begin
                    m_out[i] = a; m_lk[i] = 0;
                end else if (stb && m_lc[i] < 3) begin
                    m_lc[i]++;
                end
                if (stb) begin
                    m_hist[i].push_front(m_s2[i]);
                    void'(m_hist[i].pop_back());
                end
                m_s2[i] = m_s1[i];
                m_s1[i] = pins_raw[i];
            end
            if (chg) m_flag = 1;
            else if (ts_rd && req_en) m_flag = 0;
            m_cnt = (m_cnt + 1) % 256;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            logic [N-1:0] exp_f;
            for (int i = 0; i < N; i++) exp_f[i] = m_out[i][0];
            check(cur_req, "filt_out", int'(filt_out), int'(exp_f));
            check("R7", "tamper_flag", int'(tamper_flag), m_flag);
            check(req_en ? "R10" : "R9", "dma_req", int'(dma_req), (m_flag != 0 && req_en) ? 1 : 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [2:0] k, input logic mj, input logic as);
        rst_n = 1'b0; pins_raw = '0; ts_rd = 1'b0;
        rate_code = k; maj_en = mj; async_en = as;
        step(3);
        rst_n = 1'b1;
    endtask

    // Random pin activity with a given toggle chance in percent.
    task automatic random_run(input int n, input int pct);
        for (int t = 0; t < n; t++) begin
            for (int i = 0; i < N; i++)
                if (($urandom % 100) < pct) pins_raw[i] = ~pins_raw[i];
            step(1);
        end
    endtask

    initial begin
        void'($urandom(7));
        // R1: reset state
        do_reset(3'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R1", "reset filt_out", int'(filt_out), 0);
        check("R1", "reset flag", int'(tamper_flag), 0);
        step(1);

        // R3: strict filter, glitches of one and two samples then steady
        cur_req = "R3";
        pins_raw[0] = 1'b1; step(2); pins_raw[0] = 1'b0; step(20);
        @(negedge clk);
        check("R3", "short glitch rejected", int'(filt_out[0]), 0);
        step(1);
        pins_raw[1] = 1'b1; step(4); pins_raw[1] = 1'b0; step(20);
        pins_raw = '1; step(20);
        @(negedge clk);
        check("R3", "steady level accepted", int'(filt_out), 4'hF);
        step(1);
        random_run(400, 20);

        // R4: majority filter at code 2
        cur_req = "R4";
        do_reset(3'd2, 1'b1, 1'b0);
        random_run(800, 8);
        pins_raw = 4'b0101; step(64); random_run(400, 3);

        // R2: slowest rate, strict filter, slow toggles
        cur_req = "R2";
        do_reset(3'd7, 1'b0, 1'b0);
        for (int r = 0; r < 6; r++) begin
            pins_raw = ~pins_raw; step(900);
        end
        do_reset(3'd5, 1'b1, 1'b0);
        random_run(1500, 1);

        // R5 / R6: asynchronous mode with bounces
        cur_req = "R5/R6";
        do_reset(3'd1, 1'b0, 1'b1);
        pins_raw[2] = 1'b1; step(1); pins_raw[2] = 1'b0; step(3);
        @(negedge clk);
        check("R5", "first edge passed at once", int'(filt_out[2]), 1);
        step(1);
        step(30);
        @(negedge clk);
        check("R6", "lock released to settled level", int'(filt_out[2]), 0);
        step(1);
        random_run(600, 10);
        do_reset(3'd3, 1'b1, 1'b1);
        random_run(1200, 4);

        // R8 / R9 / R10: flag clearing and request
        cur_req = "R8";
        do_reset(3'd0, 1'b0, 1'b0);
        pins_raw = 4'b0001; step(20);
        @(negedge clk);
        check("R7", "flag set by change", int'(tamper_flag), 1);
        step(1);
        ts_rd = 1'b1; step(1); ts_rd = 1'b0; step(1);
        @(negedge clk);
        check("R9", "read ignored when request off", int'(tamper_flag), 1);
        step(1);
        req_en = 1'b1; step(1);
        @(negedge clk);
        check("R10", "request shows flag", int'(dma_req), 1);
        step(1);
        ts_rd = 1'b1; step(1); ts_rd = 1'b0;
        @(negedge clk);
        check("R8", "read clears flag", int'(tamper_flag), 0);
        step(1);
        for (int t = 0; t < 1500; t++) begin
            ts_rd = (($urandom % 100) < 15);
            if (t % 300 == 150) req_en = ~req_en;
            for (int i = 0; i < N; i++)
                if (($urandom % 100) < 6) pins_raw[i] = ~pins_raw[i];
            step(1);
        end
        ts_rd = 1'b0;
        step(5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule